// File: doc/BRIEF.md
# Minifloat Adder-Subtractor

This block adds two 12-bit floating-point words and returns their sum one clock later. Each word has a sign bit, a 6-bit biased exponent (bias 31) and a 5-bit fraction that sits below an implied leading one. Any word whose exponent field is zero stands for zero. The block has no encodings for subnormals, infinities or NaN, and it supports only one rounding behaviour: bits that fall off the low end are dropped.

Inside, the two operands are ordered by magnitude and the smaller significand is shifted right to line up with the larger. The two are then added when the signs agree and subtracted when they differ. The raw result is renormalised by a one-place right shift when it carries out, or by a left shift of the leading-zero count when a subtraction loses top bits. The result is then repacked. When the exponent runs past the top of its range the result saturates. When the exponent reaches zero or goes below it, the result is flushed to zero. A single output register holds the packed result.

Top module: `mf_addsub`

## Requirements
- R1: Word layout is sign in bit 11, exponent in bits 10:5 and fraction in bits 4:0. The sum for the operands presented before a rising edge appears after that edge, and an active-low reset clears the sum to 12'h000.
- R2: A word with exponent field 0 is zero whatever its other bits hold, and two zero operands give 12'h000.
- R3: When exactly one operand is zero, the sum equals the other operand bit for bit.
- R4: With equal signs the significands are added, and a carry out shifts the result right one place and raises the exponent by one (0_100100_11110 + 0_100010_11000 = 0_100101_00110).
- R5: With opposite signs the smaller magnitude is subtracted from the larger, and the result is renormalised by a left shift that lowers the exponent (0_011110_00000 + 1_011101_11000 = 0_011011_00000).
- R6: Bits shifted out during alignment or renormalisation are discarded with no rounding (0_100001_11100 + 0_100000_11110 = 0_100010_01101).
- R7: The result sign is that of the operand with the larger magnitude, and negating both operands negates a nonzero result.
- R8: Operands of equal magnitude and opposite sign give positive zero, 12'h000.
- R9: When both operands are nonzero and one exponent exceeds the other by more than 6, the sum equals the larger operand.
- R10: A result exponent above 63 saturates to the largest magnitude, exponent 6'b111111 and fraction 5'b11111, with the result sign.
- R11: A result exponent of 0 or below flushes the sum to 12'h000, so no output ever has exponent 0 with any other bit set.
- R12: Swapping the two operands does not change the sum.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_a | input | 12 | First operand word |
| op_b | input | 12 | Second operand word |
| sum | output | 12 | Registered sum of the operands |

## Verification
The properties assume that both operands are stable, known values at each rising edge. They also assume that the only special encoding is a zero exponent, because no word is reserved for infinity or NaN. The stimulus is driven on the falling edge, so every operand pair is settled well before the edge that registers it. The random operands use exponents spread over the full 0 to 63 range, so the zero, flush and saturation paths are all reached.

// File: rtl/mf_pkg.sv
package mf_pkg;

    // Default field widths of the minifloat word (bias 31 is implied by EXP_W)
    localparam int EXP_W_DEF  = 6;
    localparam int FRAC_W_DEF = 5;

    // Operation selected from the operand signs
    typedef enum logic {
        OP_ADD = 1'b0,
        OP_SUB = 1'b1
    } mf_op_e;

endpackage

// File: rtl/mf_order.sv
module mf_order
    import mf_pkg::*;
#(
    parameter int EXP_W  = EXP_W_DEF,
    parameter int FRAC_W = FRAC_W_DEF
) (
    input  logic [EXP_W+FRAC_W:0]   a_word,
    input  logic [EXP_W+FRAC_W:0]   b_word,
    output logic [EXP_W-1:0]        big_exp,
    output logic [FRAC_W:0]         big_sig,
    output logic [FRAC_W:0]         small_sig,
    output logic                    res_sign,
    output mf_op_e                  op
);

    localparam int MAG_W = EXP_W + FRAC_W;
    localparam int SIG_W = FRAC_W + 1;

    logic [EXP_W-1:0] exp_a, exp_b, small_exp, shift_amt;
    logic [SIG_W-1:0] sig_a, sig_b, small_raw;
    logic [MAG_W-1:0] key_a, key_b;
    logic             a_first;

    always_comb begin
        exp_a = a_word[MAG_W-1:FRAC_W];
        exp_b = b_word[MAG_W-1:FRAC_W];
        sig_a = (exp_a == '0) ? '0 : {1'b1, a_word[FRAC_W-1:0]};
        sig_b = (exp_b == '0) ? '0 : {1'b1, b_word[FRAC_W-1:0]};
        key_a = (exp_a == '0) ? '0 : a_word[MAG_W-1:0];
        key_b = (exp_b == '0) ? '0 : b_word[MAG_W-1:0];
        a_first = (key_a >= key_b);

        if (a_first) begin
            big_exp   = exp_a;
            big_sig   = sig_a;
            small_exp = exp_b;
            small_raw = sig_b;
            res_sign  = a_word[MAG_W];
        end else begin
            big_exp   = exp_b;
            big_sig   = sig_b;
            small_exp = exp_a;
            small_raw = sig_a;
            res_sign  = b_word[MAG_W];
        end

        shift_amt = big_exp - small_exp;
        if (shift_amt >= EXP_W'(SIG_W))
            small_sig = '0;
        else
            small_sig = small_raw >> shift_amt;

        op = (a_word[MAG_W] ^ b_word[MAG_W]) ? OP_SUB : OP_ADD;
    end

endmodule

// File: rtl/mf_combine.sv
module mf_combine
    import mf_pkg::*;
#(
    parameter int FRAC_W = FRAC_W_DEF
) (
    input  logic [FRAC_W:0]   big_sig,
    input  logic [FRAC_W:0]   small_sig,
    input  mf_op_e            op,
    output logic [FRAC_W+1:0] raw_sum
);

    always_comb begin
        if (op == OP_SUB)
            raw_sum = {1'b0, big_sig} - {1'b0, small_sig};
        else
            raw_sum = {1'b0, big_sig} + {1'b0, small_sig};
    end

endmodule

// File: rtl/mf_norm.sv
module mf_norm
    import mf_pkg::*;
#(
    parameter int EXP_W  = EXP_W_DEF,
    parameter int FRAC_W = FRAC_W_DEF
) (
    input  logic [FRAC_W+1:0]     raw_sum,
    input  logic [EXP_W-1:0]      exp_in,
    input  logic                  sign_in,
    output logic [EXP_W+FRAC_W:0] word_out
);

    localparam int SIG_W   = FRAC_W + 1;
    localparam int LZ_W    = $clog2(SIG_W + 1);
    localparam int EXT_W   = EXP_W + 2;
    localparam int EXP_MAX = (1 << EXP_W) - 1;

    logic [LZ_W-1:0]         lz;
    logic [FRAC_W-1:0]       frac_n;
    logic signed [EXT_W-1:0] exp_base, exp_n;

    always_comb begin
        lz = '0;
        for (int i = 0; i < SIG_W; i++) begin
            if (raw_sum[i])
                lz = LZ_W'(SIG_W - 1 - i);
        end

        exp_base = $signed({2'b00, exp_in});
        if (raw_sum[SIG_W]) begin
            frac_n = raw_sum[SIG_W-1:1];
            exp_n  = exp_base + EXT_W'(1);
        end else begin
            frac_n = FRAC_W'(raw_sum[FRAC_W-1:0] << lz);
            exp_n  = exp_base - $signed({{(EXT_W-LZ_W){1'b0}}, lz});
        end

        if (raw_sum == '0)
            word_out = '0;
        else if (exp_n > $signed(EXT_W'(EXP_MAX)))
            word_out = {sign_in, {EXP_W{1'b1}}, {FRAC_W{1'b1}}};
        else if (exp_n <= $signed(EXT_W'(0)))
            word_out = '0;
        else
            word_out = {sign_in, exp_n[EXP_W-1:0], frac_n};
    end

endmodule

// File: rtl/mf_addsub.sv
module mf_addsub
    import mf_pkg::*;
#(
    parameter int EXP_W  = EXP_W_DEF,
    parameter int FRAC_W = FRAC_W_DEF
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [EXP_W+FRAC_W:0] op_a,
    input  logic [EXP_W+FRAC_W:0] op_b,
    output logic [EXP_W+FRAC_W:0] sum
);

    localparam int WORD_W = EXP_W + FRAC_W + 1;
    localparam int MAG_W  = EXP_W + FRAC_W;
    localparam int SIG_W  = FRAC_W + 1;

    typedef struct packed {
        logic [WORD_W-1:0] sum;
    } state_t;

    state_t st_d, st_q;

    logic [EXP_W-1:0] big_exp;
    logic [SIG_W-1:0] big_sig, small_sig;
    logic             res_sign;
    mf_op_e           op;
    logic [SIG_W:0]   raw_sum;
    logic [WORD_W-1:0] packed_sum;

    mf_order #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_order (
        .a_word    (op_a),
        .b_word    (op_b),
        .big_exp   (big_exp),
        .big_sig   (big_sig),
        .small_sig (small_sig),
        .res_sign  (res_sign),
        .op        (op)
    );

    mf_combine #(.FRAC_W(FRAC_W)) u_combine (
        .big_sig   (big_sig),
        .small_sig (small_sig),
        .op        (op),
        .raw_sum   (raw_sum)
    );

    mf_norm #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_norm (
        .raw_sum   (raw_sum),
        .exp_in    (big_exp),
        .sign_in   (res_sign),
        .word_out  (packed_sum)
    );

    always_comb begin
        st_d     = st_q;
        st_d.sum = packed_sum;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign sum = st_q.sum;

    // Port-level views used by the assertions
    logic [EXP_W-1:0] ea_v, eb_v, es_v;
    logic             a_zero_v, b_zero_v;
    assign ea_v     = op_a[MAG_W-1:FRAC_W];
    assign eb_v     = op_b[MAG_W-1:FRAC_W];
    assign es_v     = sum[MAG_W-1:FRAC_W];
    assign a_zero_v = (ea_v == '0);
    assign b_zero_v = (eb_v == '0);

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (sum == '0));

    // R2
    zero_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (a_zero_v && b_zero_v) |=> (sum == '0));

    // R3
    zero_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (a_zero_v && !b_zero_v) |=> (sum == $past(op_b)));

    // R8
    cancel_pos_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!a_zero_v && (op_a[MAG_W-1:0] == op_b[MAG_W-1:0]) && (op_a[MAG_W] != op_b[MAG_W]))
        |=> (sum == '0));

    // R9
    far_operand_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!a_zero_v && !b_zero_v && ({1'b0, ea_v} > ({1'b0, eb_v} + (EXP_W+1)'(SIG_W))))
        |=> (sum == $past(op_a)));

    // R7
    sign_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!a_zero_v && !b_zero_v && (op_a[MAG_W-1:0] > op_b[MAG_W-1:0]))
        |=> ((sum == '0) || (sum[MAG_W] == $past(op_a[MAG_W]))));

    // R11
    flush_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (es_v == '0) |-> (sum == '0));

endmodule

// File: tb/sim_mf_addsub.sv
module sim_mf_addsub;

    logic        clk;
    logic        rst_n;
    logic [11:0] op_a, op_b;
    logic [11:0] sum;

    int checks = 0;
    int errors = 0;

    mf_addsub u0 (
        .clk   (clk),
        .rst_n (rst_n),
        .op_a  (op_a),
        .op_b  (op_b),
        .sum   (sum)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    // Behavioural reference: integer arithmetic on magnitudes
    function automatic logic [11:0] ref_add(input logic [11:0] a, input logic [11:0] b);
        int ea, eb, ka, kb, mb, ms, d, r, e;
        logic sgn;
        logic same;
        ea = int'(a[10:5]);
        eb = int'(b[10:5]);
        ka = (ea == 0) ? 0 : int'(a[10:0]);
        kb = (eb == 0) ? 0 : int'(b[10:0]);
        same = (a[11] == b[11]);
        if (ka >= kb) begin
            sgn = a[11];
            e   = ea;
            mb  = (ea == 0) ? 0 : 32 + int'(a[4:0]);
            ms  = (eb == 0) ? 0 : 32 + int'(b[4:0]);
            d   = ea - eb;
        end else begin
            sgn = b[11];
            e   = eb;
            mb  = (eb == 0) ? 0 : 32 + int'(b[4:0]);
            ms  = (ea == 0) ? 0 : 32 + int'(a[4:0]);
            d   = eb - ea;
        end
        ms = (d >= 6) ? 0 : (ms >> d);
        r  = same ? (mb + ms) : (mb - ms);
        if (r == 0) return 12'h000;
        while (r >= 64) begin r = r >> 1; e = e + 1; end
        while (r < 32)  begin r = r << 1; e = e - 1; end
        if (e > 63) return {sgn, 6'h3f, 5'h1f};
        if (e <= 0) return 12'h000;
        return {sgn, 6'(e), 5'(r)};
    endfunction

    task automatic check(input string tag, input logic [11:0] got, input logic [11:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %b_%b_%b expected %b_%b_%b", tag,
                     got[11], got[10:5], got[4:0], exp[11], exp[10:5], exp[4:0]);
        end
    endtask

    // Drive on the falling edge, sample just after the next rising edge
    task automatic apply(input logic [11:0] a, input logic [11:0] b, input string tag,
                         output logic [11:0] got);
        @(negedge clk);
        op_a = a;
        op_b = b;
        @(posedge clk);
        #1;
        got = sum;
        check(tag, got, ref_add(a, b));
    endtask

    task automatic apply_lit(input logic [11:0] a, input logic [11:0] b, input string tag,
                             input logic [11:0] lit);
        logic [11:0] got;
        apply(a, b, tag, got);
        check({tag, " literal"}, got, lit);
    endtask

    initial begin
        #2_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [11:0] g1, g2;
        op_a  = 12'h000;
        op_b  = 12'h000;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset", sum, 12'h000);
        @(negedge clk);
        rst_n = 1'b1;

        // R2 zero operands, including zero words with stray bits
        apply_lit(12'b0_000000_00000, 12'b0_000000_00000, "R2", 12'h000);
        apply_lit(12'b1_000000_10101, 12'b0_000000_00011, "R2 stray", 12'h000);
        // R3 one zero operand
        apply_lit(12'b0_000000_00000, 12'b0_100001_00100, "R3 a-zero", 12'b0_100001_00100);
        apply_lit(12'b1_100000_01000, 12'b1_000000_11111, "R3 b-zero", 12'b1_100000_01000);
        // R4 same-sign addition with and without carry
        apply_lit(12'b0_100100_11110, 12'b0_100010_11000, "R4 carry", 12'b0_100101_00110);
        apply_lit(12'b0_100001_00100, 12'b0_100000_01000, "R4 no-carry", 12'b0_100001_11000);
        // R5 subtraction with left renormalisation
        apply_lit(12'b0_011110_00000, 12'b1_011101_11000, "R5", 12'b0_011011_00000);
        // R6 truncation
        apply_lit(12'b0_100001_11100, 12'b0_100000_11110, "R6 carry-trunc", 12'b0_100010_01101);
        apply_lit(12'b0_100001_01110, 12'b0_100000_00001, "R6 align-trunc", 12'b0_100001_11110);
        // R7 sign rules
        apply_lit(12'b1_100100_11110, 12'b1_100010_11000, "R7 both-neg", 12'b1_100101_00110);
        apply_lit(12'b1_100010_00000, 12'b0_100001_00000, "R7 larger-neg", 12'b1_100001_00000);
        apply_lit(12'b0_100001_00000, 12'b1_100010_00000, "R7 larger-neg-b", 12'b1_100001_00000);
        // R8 exact cancellation
        apply_lit(12'b0_100000_10101, 12'b1_100000_10101, "R8", 12'h000);
        apply_lit(12'b1_111111_11111, 12'b0_111111_11111, "R8 top", 12'h000);
        // R9 far operand
        apply_lit(12'b0_101000_00000, 12'b1_100000_11111, "R9 sub", 12'b0_101000_00000);
        apply_lit(12'b1_000010_11111, 12'b1_110000_00001, "R9 add", 12'b1_110000_00001);
        // R10 saturation
        apply_lit(12'b0_111111_11111, 12'b0_111111_11111, "R10 pos", 12'b0_111111_11111);
        apply_lit(12'b1_111111_00000, 12'b1_111111_00000, "R10 neg", 12'b1_111111_11111);
        // R11 underflow flush
        apply_lit(12'b0_000010_00000, 12'b1_000001_11111, "R11 deep", 12'h000);
        apply_lit(12'b0_000001_10000, 12'b1_000001_00000, "R11 edge", 12'h000);

        // Random pairs against the model, each also replayed swapped (R12)
        for (int n = 0; n < 400; n++) begin
            logic [11:0] ra, rb;
            ra = 12'($urandom);
            rb = 12'($urandom);
            if (n % 4 == 1) rb = {~ra[11], ra[10:0]};
            if (n % 4 == 2) rb[10:5] = ra[10:5] - 6'(n % 3);
            apply(ra, rb, "R4/R5/R7 random", g1);
            apply(rb, ra, "R12 swapped", g2);
            check("R12 order", g2, g1);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule